// File: doc/BRIEF.md
# Scan Path Select Register

This block holds the number of the scan chain that a test access port routes between its serial input and output. It sits on the data-register side of the port. When the chain-select instruction is current, the port's capture, shift and update strobes act on it. Capture preloads a fixed marker pattern. Shift moves a new chain number in from the serial input, least significant bit first, while the old stage contents leave on the serial output. Update copies the shifted value into a separate holding register, and that register drives the chain number.

The held number stays in force while other instructions run. Only a later update under the chain-select instruction replaces it. The number drives a one-of-N selector. The selector picks the serial output of one external scan chain, and the test instructions that walk a chain use that path. A synchronous reset selects chain 3. The serial output of the shift stage is re-timed on the falling clock edge, so a receiver can sample it on the next rising edge.

Top module: `scan_path_select`

## Requirements
- R1: While reset is high at a rising edge, the held chain number becomes 3 and the stage serial output becomes 0 at the following falling edge.
- R2: A capture strobe with the select instruction active loads the shift stage with binary 1000 (bit 3 set, bits 2..0 clear).
- R3: A shift strobe with the instruction active moves the stage one place toward bit 0. The serial input enters at bit 3 and bit 0 is presented on the serial output, so bits leave and enter least significant first.
- R4: An update strobe with the instruction active copies the shift stage into the held chain number. Capture and shift never alter the held number.
- R5: When the instruction-active flag is low, capture, shift and update strobes leave both the shift stage and the held chain number unchanged.
- R6: Without an active update, the held chain number keeps its value across any number of cycles and across capture and shift activity.
- R7: The stage serial output changes only on the falling clock edge, to the value of stage bit 0 at that edge.
- R8: The chain output equals the serial output of the external chain whose index equals the held chain number.
- R9: When more than four bits are shifted, the bits that leave after the captured pattern are the first bits shifted in, and an update keeps the last four bits shifted in.
- R10: When several strobes are high together, capture takes priority over shift and shift takes priority over update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test logic reset |
| sel_active | input | 1 | The chain-select instruction is the current instruction |
| capture_dr | input | 1 | Port is in the data-register capture state |
| shift_dr | input | 1 | Port is in the data-register shift state |
| update_dr | input | 1 | Port is in the data-register update state |
| tdi | input | 1 | Serial test data in |
| stage_tdo | output | 1 | Shift-stage serial out, re-timed on the falling edge |
| chain_num | output | 4 | Held selected chain number |
| chain_so | input | 16 | Serial outputs of the external scan chains |
| chain_tdo | output | 1 | Serial output of the selected chain |

## Verification
The chain number is loaded with the values 5, 12 and 6 and with a six-bit stream. Every load also reads back the captured 1000 marker. This separates a capture of the wrong pattern, a shift in the wrong direction and an update that takes the wrong bits. The six-bit stream shows whether the stage acts as a first-in first-out delay line and keeps the last four bits. Strobes with the instruction flag low, and captures and shifts with no update, show that the held number moves only on an active update. A read of the serial output just after a rising edge and again after the falling edge shows on which edge it changes. A cycle with capture and update high together shows that capture wins. The selector is driven with an asymmetric pattern on the chain outputs, so a wrong index shows as a wrong bit.

// File: rtl/scan_sel_pkg.sv
package scan_sel_pkg;

    localparam int unsigned SEL_W_DEF       = 4;
    localparam int unsigned NUM_CHAINS_DEF  = 16;
    localparam int unsigned RESET_CHAIN_DEF = 3;

    // One cycle's data-register strobes from the port controller.
    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } dr_strobe_t;

    // Action applied to the select register in one cycle.
    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_CAPTURE = 2'd1,
        ACT_SHIFT   = 2'd2,
        ACT_UPDATE  = 2'd3
    } sel_action_t;

    // Capture wins over shift, and shift wins over update.
    function automatic sel_action_t decode_action(input dr_strobe_t s, input logic active);
        sel_action_t a;
        a = ACT_IDLE;
        if (active) begin
            if (s.capture)     a = ACT_CAPTURE;
            else if (s.shift)  a = ACT_SHIFT;
            else if (s.update) a = ACT_UPDATE;
        end
        return a;
    endfunction

    // Marker pattern: only the top bit set.
    function automatic logic [SEL_W_DEF-1:0] marker_pattern();
        logic [SEL_W_DEF-1:0] v;
        v = '0;
        v[SEL_W_DEF-1] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/scan_sel_stage.sv
module scan_sel_stage
    import scan_sel_pkg::*;
#(
    parameter int unsigned   SEL_W       = SEL_W_DEF,
    parameter logic [SEL_W-1:0] CAPTURE_VAL = marker_pattern()
) (
    input  logic             tck,
    input  logic             rst,
    input  sel_action_t      action,
    input  logic             tdi,
    output logic [SEL_W-1:0] stage_q
);

    logic [SEL_W-1:0] stage_d;

    // One cell per bit; the top cell takes the serial input.
    for (genvar b = 0; b < SEL_W; b++) begin : g_cell
        logic shift_src;
        if (b == SEL_W - 1) begin : g_top
            assign shift_src = tdi;
        end else begin : g_inner
            assign shift_src = stage_q[b+1];
        end

        always_comb begin
            unique case (action)
                ACT_CAPTURE: stage_d[b] = CAPTURE_VAL[b];
                ACT_SHIFT:   stage_d[b] = shift_src;
                default:     stage_d[b] = stage_q[b];
            endcase
        end
    end

    always_ff @(posedge tck) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

endmodule

// File: rtl/scan_sel_hold.sv
module scan_sel_hold
    import scan_sel_pkg::*;
#(
    parameter int unsigned SEL_W       = SEL_W_DEF,
    parameter int unsigned RESET_CHAIN = RESET_CHAIN_DEF
) (
    input  logic             tck,
    input  logic             rst,
    input  sel_action_t      action,
    input  logic [SEL_W-1:0] stage_q,
    output logic [SEL_W-1:0] hold_q
);

    localparam logic [SEL_W-1:0] RESET_VAL = SEL_W'(RESET_CHAIN);

    always_ff @(posedge tck) begin
        if (rst)                        hold_q <= RESET_VAL;
        else if (action == ACT_UPDATE)  hold_q <= stage_q;
    end

endmodule

// File: rtl/scan_sel_outstage.sv
module scan_sel_outstage (
    input  logic tck,
    input  logic rst,
    input  logic lsb,
    output logic tdo_q
);

    // Re-timed on the falling edge so the receiver samples half a cycle later.
    always_ff @(negedge tck) begin
        if (rst) tdo_q <= 1'b0;
        else     tdo_q <= lsb;
    end

endmodule

// File: rtl/scan_sel_chain_mux.sv
module scan_sel_chain_mux
    import scan_sel_pkg::*;
#(
    parameter int unsigned SEL_W      = SEL_W_DEF,
    parameter int unsigned NUM_CHAINS = NUM_CHAINS_DEF
) (
    input  logic [SEL_W-1:0]      sel,
    input  logic [NUM_CHAINS-1:0] chain_so,
    output logic                  chain_tdo
);

    logic [NUM_CHAINS-1:0] hit;

    // AND-OR selector: a number with no chain yields 0.
    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_leg
        assign hit[c] = (sel == SEL_W'(c)) & chain_so[c];
    end

    assign chain_tdo = |hit;

endmodule

// File: rtl/scan_path_select.sv
module scan_path_select
    import scan_sel_pkg::*;
#(
    parameter int unsigned SEL_W       = SEL_W_DEF,
    parameter int unsigned NUM_CHAINS  = NUM_CHAINS_DEF,
    parameter int unsigned RESET_CHAIN = RESET_CHAIN_DEF
) (
    input  logic                  tck,
    input  logic                  rst,
    input  logic                  sel_active,
    input  logic                  capture_dr,
    input  logic                  shift_dr,
    input  logic                  update_dr,
    input  logic                  tdi,
    output logic                  stage_tdo,
    output logic [SEL_W-1:0]      chain_num,
    input  logic [NUM_CHAINS-1:0] chain_so,
    output logic                  chain_tdo
);

    localparam logic [SEL_W-1:0] CAPTURE_VAL = {1'b1, {(SEL_W-1){1'b0}}};

    dr_strobe_t       strobe;
    sel_action_t      action;
    logic [SEL_W-1:0] stage_q;

    assign strobe = '{capture: capture_dr, shift: shift_dr, update: update_dr};
    assign action = decode_action(strobe, sel_active);

    scan_sel_stage #(
        .SEL_W       (SEL_W),
        .CAPTURE_VAL (CAPTURE_VAL)
    ) u_stage (
        .tck     (tck),
        .rst     (rst),
        .action  (action),
        .tdi     (tdi),
        .stage_q (stage_q)
    );

    scan_sel_hold #(
        .SEL_W       (SEL_W),
        .RESET_CHAIN (RESET_CHAIN)
    ) u_hold (
        .tck     (tck),
        .rst     (rst),
        .action  (action),
        .stage_q (stage_q),
        .hold_q  (chain_num)
    );

    scan_sel_outstage u_out (
        .tck   (tck),
        .rst   (rst),
        .lsb   (stage_q[0]),
        .tdo_q (stage_tdo)
    );

    scan_sel_chain_mux #(
        .SEL_W      (SEL_W),
        .NUM_CHAINS (NUM_CHAINS)
    ) u_mux (
        .sel       (chain_num),
        .chain_so  (chain_so),
        .chain_tdo (chain_tdo)
    );

endmodule

// File: rtl/scan_path_select_chk.sv
module scan_path_select_chk #(
    parameter int unsigned SEL_W       = 4,
    parameter int unsigned RESET_CHAIN = 3
) (
    input logic             tck,
    input logic             rst,
    input logic             sel_active,
    input logic             capture_dr,
    input logic             shift_dr,
    input logic             update_dr,
    input logic             tdi,
    input logic             stage_tdo,
    input logic [SEL_W-1:0] chain_num,
    input logic [SEL_W-1:0] stage_q
);

    localparam logic [SEL_W-1:0] MARK = {1'b1, {(SEL_W-1){1'b0}}};

    AST_RESET_CHAIN: assert property (@(posedge tck)
        rst |=> (chain_num == SEL_W'(RESET_CHAIN))); // R1

    AST_CAPTURE_MARK: assert property (@(posedge tck) disable iff (rst)
        (sel_active && capture_dr) |=> (stage_q == MARK)); // R2

    AST_SHIFT_ENTRY: assert property (@(posedge tck) disable iff (rst)
        (sel_active && shift_dr && !capture_dr) |=> (stage_q[SEL_W-1] == $past(tdi))); // R3

    AST_UPDATE_LOAD: assert property (@(posedge tck) disable iff (rst)
        (sel_active && update_dr && !capture_dr && !shift_dr) |=> (chain_num == $past(stage_q))); // R4

    AST_INACTIVE_STAGE: assert property (@(posedge tck) disable iff (rst)
        !sel_active |=> $stable(stage_q)); // R5

    AST_HOLD_STABLE: assert property (@(posedge tck) disable iff (rst)
        !(sel_active && update_dr && !capture_dr && !shift_dr) |=> $stable(chain_num)); // R6

    AST_TDO_FALL: assert property (@(negedge tck) disable iff (rst)
        !rst |=> (stage_tdo == $past(stage_q[0]))); // R7

endmodule

bind scan_path_select scan_path_select_chk #(
    .SEL_W       (SEL_W),
    .RESET_CHAIN (RESET_CHAIN)
) u_chk (
    .tck        (tck),
    .rst        (rst),
    .sel_active (sel_active),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .tdi        (tdi),
    .stage_tdo  (stage_tdo),
    .chain_num  (chain_num),
    .stage_q    (stage_q)
);

// File: tb/scan_path_select_test.sv
module scan_path_select_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic        tck = 1'b0;
    logic        rst = 1'b1;
    logic        sel_active = 1'b0;
    logic        capture_dr = 1'b0;
    logic        shift_dr = 1'b0;
    logic        update_dr = 1'b0;
    logic        tdi = 1'b0;
    logic        stage_tdo;
    logic [3:0]  chain_num;
    logic [15:0] chain_so = 16'hA5C3;
    logic        chain_tdo;

    int checks = 0;
    int errors = 0;
    logic last_tdo;

    always #2 tck = ~tck;

    scan_path_select uut (
        .tck        (tck),
        .rst        (rst),
        .sel_active (sel_active),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .stage_tdo  (stage_tdo),
        .chain_num  (chain_num),
        .chain_so   (chain_so),
        .chain_tdo  (chain_tdo)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock: drive just after a rising edge, sample the serial out after the falling edge.
    task automatic cyc(input logic c, input logic s, input logic u, input logic d);
        capture_dr = c; shift_dr = s; update_dr = u; tdi = d;
        @(negedge tck); #1;
        last_tdo = stage_tdo;
        @(posedge tck); #1;
        capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
    endtask

    task automatic shift_word(input logic [3:0] din, output logic [3:0] dout);
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, 1'b1, 1'b0, din[i]);
            dout[i] = last_tdo;
        end
    endtask

    task automatic check_mux(input string req, input int idx);
        check(req, "selected chain output", int'(chain_tdo), int'(chain_so[idx]));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge tck);
        #1;
        check("R1", "chain after reset", int'(chain_num), 3);
        @(negedge tck); #1;
        check("R1", "serial out after reset", int'(stage_tdo), 0);
        check_mux("R8", 3);
        rst = 1'b0;
        @(posedge tck); #1;
    endtask

    task automatic t_load_five();
        logic [3:0] got;
        sel_active = 1'b1;
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        shift_word(4'd5, got);
        check("R2", "captured marker read out", int'(got), 8);
        check("R4", "chain unchanged before update", int'(chain_num), 3);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R4", "chain after update", int'(chain_num), 5);
        check_mux("R8", 5);
    endtask

    task automatic t_load_twelve();
        logic [3:0] got;
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        shift_word(4'd12, got);
        check("R3", "lsb-first read out", int'(got), 8);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R3", "chain after lsb-first load", int'(chain_num), 12);
        check_mux("R8", 12);
        chain_so = ~chain_so; #1;
        check_mux("R8", 12);
    endtask

    task automatic t_long_stream();
        logic [5:0] s;
        logic [5:0] got;
        s = 6'b10_1101;
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) begin
            cyc(1'b0, 1'b1, 1'b0, s[i]);
            got[i] = last_tdo;
        end
        check("R9", "marker leaves first", int'(got[3:0]), 8);
        check("R9", "first bits in leave next", int'(got[5:4]), int'(s[1:0]));
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R9", "last four bits kept", int'(chain_num), int'(s[5:2]));
    endtask

    task automatic t_inactive();
        logic [3:0] got;
        logic       tdo_before;
        int         chain_before;
        chain_before = int'(chain_num);
        @(negedge tck); #1;
        tdo_before = stage_tdo;
        @(posedge tck); #1;
        sel_active = 1'b0;
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        check("R5", "serial out after inactive capture", int'(last_tdo), int'(tdo_before));
        shift_word(4'hF, got);
        check("R5", "serial out during inactive shift", int'(got), tdo_before ? 15 : 0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R5", "chain after inactive update", int'(chain_num), chain_before);
    endtask

    task automatic t_persist();
        logic [3:0] got;
        int         chain_before;
        chain_before = int'(chain_num);
        sel_active = 1'b1;
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        shift_word(4'd6, got);
        sel_active = 1'b0;
        repeat (5) cyc(1'b0, 1'b0, 1'b0, 1'b1);
        check("R6", "chain held with no update", int'(chain_num), chain_before);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R6", "chain held after inactive update", int'(chain_num), chain_before);
        sel_active = 1'b1;
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R6", "chain after later active update", int'(chain_num), 6);
    endtask

    task automatic t_falling_edge();
        logic [3:0] got;
        // Leave bit 0 set, then capture clears it.
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        shift_word(4'd1, got);
        @(negedge tck); #1;
        check("R7", "serial out shows stage bit 0", int'(stage_tdo), 1);
        @(posedge tck); #1;
        capture_dr = 1'b1;
        @(posedge tck); #1;
        capture_dr = 1'b0;
        check("R7", "serial out steady after rising edge", int'(stage_tdo), 1);
        @(negedge tck); #1;
        check("R7", "serial out after falling edge", int'(stage_tdo), 0);
        @(posedge tck); #1;
    endtask

    task automatic t_priority();
        logic [3:0] got;
        int         chain_before;
        chain_before = int'(chain_num);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        shift_word(4'd9, got);
        // Capture and update together: capture wins, chain unchanged.
        cyc(1'b1, 1'b0, 1'b1, 1'b0);
        check("R10", "capture beats update", int'(chain_num), chain_before);
        // Shift and update together: shift wins.
        cyc(1'b0, 1'b1, 1'b1, 1'b1);
        check("R10", "shift beats update", int'(chain_num), chain_before);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R10", "stage after capture then shift", int'(chain_num), 12);
    endtask

    task automatic t_reset_again();
        rst = 1'b1;
        @(posedge tck); #1;
        rst = 1'b0;
        check("R1", "chain after mid-run reset", int'(chain_num), 3);
        check_mux("R8", 3);
    endtask

    initial begin
        repeat (20000) @(posedge tck);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_load_five();
        t_load_twelve();
        t_long_stream();
        t_inactive();
        t_persist();
        t_falling_edge();
        t_priority();
        t_reset_again();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule